// File: doc/BRIEF.md
# Character Display Bus Sequencer

This block runs single read or write accesses on a parallel bus for character displays. The bus has a register-select line, a read/write line, two enable strobes for panels that carry two controllers, and a 16-bit data bus that can be tri-stated. A host hands over one command through a valid/ready pair. The command holds the direction, the register-select value, the enable to use and one write byte. The block then runs the access as a fixed series of phases. It reports completion with a one-cycle pulse, and for a read it presents the byte it captured in that same cycle.

The lengths of the phases come from timing inputs that are counted in clock cycles. Writes and reads each have their own setup, strobe and hold counts. A shared recovery gap follows every access before the next one can start. All of these inputs are captured when a command is accepted, so the host may change them at any time.

The state machine has six states:
- `ST_IDLE`: ready to accept a command.
- `ST_SETUP`: control lines set up.
- `ST_STROBE`: the selected enable is high.
- `ST_HOLD`: control lines held.
- `ST_GAP`: recovery gap.
- `ST_DONE`: one-cycle completion.

The transitions are:
- `ST_IDLE` goes to `ST_SETUP` on accept when the setup count is non-zero, otherwise to `ST_STROBE`.
- `ST_SETUP` goes to `ST_STROBE`, and `ST_STROBE` goes to `ST_HOLD`, when the phase counter expires.
- `ST_HOLD` goes to `ST_GAP` when the gap count is non-zero, otherwise to `ST_DONE`.
- `ST_GAP` goes to `ST_DONE` when its counter expires.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `charlcd_bus_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, both enables, `lcd_doe`, `lcd_rs` and `lcd_rw` are 0.
- R2: A command is taken at a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 up to and including the `done` cycle, and it returns to 1 in the cycle after `done`.
- R3: The setup phase lasts exactly the selected setup count of cycles (0 to 31). A count of 0 skips the phase, so the strobe starts in the first cycle after the accept edge.
- R4: The strobe phase lasts the selected strobe count of cycles (1 to 63), and a count of 0 acts as 1. Only the chosen enable is high during the strobe phase: `req_sel`=0 selects `lcd_en0` and `req_sel`=1 selects `lcd_en1`. Both enables are 0 at all other times.
- R5: The hold phase lasts the selected hold count of cycles (1 to 15), and a count of 0 acts as 1.
- R6: After the hold phase, `cfg_gap` cycles (0 to 15) pass before `done` is 1 for exactly one cycle.
- R7: During setup, strobe and hold, `lcd_rs` equals the command's register-select bit and `lcd_rw` is 1 for a read and 0 for a write, and both stay constant. Outside these phases both are 0.
- R8: On a write, `lcd_doe` is 1 from the first setup cycle through the last hold cycle, and `lcd_dout` is {8'h00, write byte}. `lcd_doe` is 0 on reads, in the gap, at done and in idle. `lcd_dout` is 0 whenever `lcd_doe` is 0.
- R9: On a read, `rdata` in the `done` cycle equals `lcd_din` as sampled at the clock edge that ends the last strobe cycle.
- R10: Changes to any `cfg_*` input after the accept edge do not alter the access in progress.
- R11: Writes use the `cfg_wr_*` counts and reads use the `cfg_rd_*` counts. The counts for the other direction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Block is idle and takes a command |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_rs | input | 1 | Register-select value for the access |
| req_sel | input | 1 | Enable choice: 0 = lcd_en0, 1 = lcd_en1 |
| req_wdata | input | 8 | Byte to write |
| cfg_wr_setup | input | 5 | Write setup cycles |
| cfg_wr_strobe | input | 6 | Write strobe cycles (0 acts as 1) |
| cfg_wr_hold | input | 4 | Write hold cycles (0 acts as 1) |
| cfg_rd_setup | input | 5 | Read setup cycles |
| cfg_rd_strobe | input | 6 | Read strobe cycles (0 acts as 1) |
| cfg_rd_hold | input | 4 | Read hold cycles (0 acts as 1) |
| cfg_gap | input | 4 | Recovery cycles between accesses |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte, valid with done on reads |
| lcd_rs | output | 1 | Register-select line |
| lcd_rw | output | 1 | Read/write line |
| lcd_en0 | output | 1 | Enable strobe, first controller |
| lcd_en1 | output | 1 | Enable strobe, second controller |
| lcd_dout | output | 16 | Data bus output value |
| lcd_doe | output | 1 | Data bus output enable |
| lcd_din | input | 8 | Data bus input, low byte |

## Verification
The hardest case to reach from the ports is a change to the timing inputs while an access is running, since a correct block hides it completely. To reach it, the bench rewrites every `cfg_*` input with fresh random values on each cycle after the accept edge. The per-cycle expectation, however, is built only from the values present at acceptance. For read capture, the bench drives a different `lcd_din` value in every cycle. Only a capture at the last strobe edge can then match the expected byte, and capturing one cycle early or late gives a different value. Directed accesses also cover the counts of zero and the maximum counts for each phase.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP,
        ST_DONE
    } lcd_state_e;

endpackage

// File: rtl/charlcd_cfg_latch.sv
// Captures the timing set that belongs to the accepted direction, with
// zero strobe/hold counts promoted to one cycle.
module charlcd_cfg_latch #(
    parameter int SU_W = 5,
    parameter int ST_W = 6,
    parameter int HO_W = 4,
    parameter int GP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            pick_read,
    input  logic [SU_W-1:0] wr_su,
    input  logic [ST_W-1:0] wr_st,
    input  logic [HO_W-1:0] wr_ho,
    input  logic [SU_W-1:0] rd_su,
    input  logic [ST_W-1:0] rd_st,
    input  logic [HO_W-1:0] rd_ho,
    input  logic [GP_W-1:0] gap_in,
    output logic [SU_W-1:0] d_su,
    output logic [ST_W-1:0] d_st,
    output logic [SU_W-1:0] q_su,
    output logic [ST_W-1:0] q_st,
    output logic [HO_W-1:0] q_ho,
    output logic [GP_W-1:0] q_gap
);
    logic [ST_W-1:0] raw_st;
    logic [HO_W-1:0] raw_ho;
    logic [HO_W-1:0] d_ho;

    always_comb begin
        d_su   = pick_read ? rd_su : wr_su;
        raw_st = pick_read ? rd_st : wr_st;
        raw_ho = pick_read ? rd_ho : wr_ho;
        d_st   = (raw_st == '0) ? ST_W'(1) : raw_st;
        d_ho   = (raw_ho == '0) ? HO_W'(1) : raw_ho;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_su  <= '0;
            q_st  <= ST_W'(1);
            q_ho  <= HO_W'(1);
            q_gap <= '0;
        end else if (load) begin
            q_su  <= d_su;
            q_st  <= d_st;
            q_ho  <= d_ho;
            q_gap <= gap_in;
        end
    end
endmodule

// File: rtl/charlcd_phase_cnt.sv
// Down counter for the current phase; reports expiry when it reaches zero.
module charlcd_phase_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/charlcd_bus_ctrl.sv
module charlcd_bus_ctrl
    import charlcd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BUS_W  = 16,
    parameter int SU_W   = 5,
    parameter int ST_W   = 6,
    parameter int HO_W   = 4,
    parameter int GP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic              req_rs,
    input  logic              req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SU_W-1:0]   cfg_wr_setup,
    input  logic [ST_W-1:0]   cfg_wr_strobe,
    input  logic [HO_W-1:0]   cfg_wr_hold,
    input  logic [SU_W-1:0]   cfg_rd_setup,
    input  logic [ST_W-1:0]   cfg_rd_strobe,
    input  logic [HO_W-1:0]   cfg_rd_hold,
    input  logic [GP_W-1:0]   cfg_gap,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_en0,
    output logic              lcd_en1,
    output logic [BUS_W-1:0]  lcd_dout,
    output logic              lcd_doe,
    input  logic [DATA_W-1:0] lcd_din
);
    localparam int W_A   = (SU_W > ST_W) ? SU_W : ST_W;
    localparam int W_B   = (HO_W > GP_W) ? HO_W : GP_W;
    localparam int CNT_W = (W_A > W_B) ? W_A : W_B;

    lcd_state_e state_q, state_d;

    logic              accept;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic [SU_W-1:0]   d_su, q_su;
    logic [ST_W-1:0]   d_st, q_st;
    logic [HO_W-1:0]   q_ho;
    logic [GP_W-1:0]   q_gap;
    logic              rd_q, rs_q, sel_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    assign accept = req_valid && req_ready;

    charlcd_cfg_latch #(
        .SU_W(SU_W), .ST_W(ST_W), .HO_W(HO_W), .GP_W(GP_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .pick_read (req_read),
        .wr_su     (cfg_wr_setup),
        .wr_st     (cfg_wr_strobe),
        .wr_ho     (cfg_wr_hold),
        .rd_su     (cfg_rd_setup),
        .rd_st     (cfg_rd_strobe),
        .rd_ho     (cfg_rd_hold),
        .gap_in    (cfg_gap),
        .d_su      (d_su),
        .d_st      (d_st),
        .q_su      (q_su),
        .q_st      (q_st),
        .q_ho      (q_ho),
        .q_gap     (q_gap)
    );

    charlcd_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Command capture and read sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            rs_q    <= 1'b0;
            sel_q   <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                rd_q    <= req_read;
                rs_q    <= req_rs;
                sel_q   <= req_sel;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_STROBE && cnt_zero && rd_q)
                rdata_q <= lcd_din;
        end
    end

    // Next state and phase counter reload
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    cnt_load = 1'b1;
                    if (d_su != '0) begin
                        state_d = ST_SETUP;
                        cnt_val = CNT_W'(d_su) - CNT_W'(1);
                    end else begin
                        state_d = ST_STROBE;
                        cnt_val = CNT_W'(d_st) - CNT_W'(1);
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d  = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(q_st) - CNT_W'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    state_d  = ST_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(q_ho) - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    if (q_gap != '0) begin
                        state_d  = ST_GAP;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(q_gap) - CNT_W'(1);
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_zero)
                    state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        lcd_rs    = 1'b0;
        lcd_rw    = 1'b0;
        lcd_en0   = 1'b0;
        lcd_en1   = 1'b0;
        lcd_doe   = 1'b0;
        lcd_dout  = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SETUP, ST_HOLD: begin
                lcd_rs  = rs_q;
                lcd_rw  = rd_q;
                lcd_doe = !rd_q;
            end
            ST_STROBE: begin
                lcd_rs  = rs_q;
                lcd_rw  = rd_q;
                lcd_doe = !rd_q;
                lcd_en0 = !sel_q;
                lcd_en1 = sel_q;
            end
            ST_GAP: ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        if (lcd_doe)
            lcd_dout = {{(BUS_W-DATA_W){1'b0}}, wdata_q};
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/charlcd_bus_ctrl_chk.sv
module charlcd_bus_ctrl_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done,
    input logic             lcd_rs,
    input logic             lcd_rw,
    input logic             lcd_en0,
    input logic             lcd_en1,
    input logic             lcd_doe,
    input logic [BUS_W-1:0] lcd_dout
);
    p_one_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcd_en0 && lcd_en1));

    p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw |-> !lcd_doe);

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_doe |-> (lcd_dout == '0));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ctl_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en0 || lcd_en1) |=> ($stable(lcd_rs) && $stable(lcd_rw)));

    p_no_strobe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(lcd_en0 || lcd_en1 || lcd_doe));
endmodule

bind charlcd_bus_ctrl charlcd_bus_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_en0   (lcd_en0),
    .lcd_en1   (lcd_en1),
    .lcd_doe   (lcd_doe),
    .lcd_dout  (lcd_dout)
);

// File: tb/charlcd_bus_ctrl_tb.sv
module charlcd_bus_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_read = 1'b0, req_rs = 1'b0, req_sel = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [4:0]  cfg_wr_setup = '0, cfg_rd_setup = '0;
    logic [5:0]  cfg_wr_strobe = '0, cfg_rd_strobe = '0;
    logic [3:0]  cfg_wr_hold = '0, cfg_rd_hold = '0, cfg_gap = '0;
    logic [7:0]  lcd_din = '0;
    logic        req_ready, done, lcd_rs, lcd_rw, lcd_en0, lcd_en1, lcd_doe;
    logic [7:0]  rdata;
    logic [15:0] lcd_dout;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    charlcd_bus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_rs(req_rs), .req_sel(req_sel), .req_wdata(req_wdata),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe),
        .cfg_wr_hold(cfg_wr_hold), .cfg_rd_setup(cfg_rd_setup),
        .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_gap(cfg_gap), .done(done), .rdata(rdata),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en0(lcd_en0), .lcd_en1(lcd_en1),
        .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [7:0] din_pat(input logic [7:0] base, input int i);
        return base ^ 8'((i * 37) + 11);
    endfunction

    task automatic scramble_cfg();
        cfg_wr_setup  = 5'($urandom);
        cfg_wr_strobe = 6'($urandom);
        cfg_wr_hold   = 4'($urandom);
        cfg_rd_setup  = 5'($urandom);
        cfg_rd_strobe = 6'($urandom);
        cfg_rd_hold   = 4'($urandom);
        cfg_gap       = 4'($urandom);
    endtask

    task automatic run_access(input bit rd, input bit rs, input bit sel,
                              input logic [7:0] wd,
                              input int ws, input int wt, input int wh,
                              input int rsu, input int rt, input int rh,
                              input int g, input bit mess);
        int s, t, h, total, first_en, en_cnt, act_cnt, done_idx, done_cnt;
        bit bad_ctl, bad_data, bad_ready, bad_line;
        logic [7:0] base, exp_rd, got_rd;
        // R11: only the counts of the requested direction apply
        s = rd ? rsu : ws;
        t = clamp1(rd ? rt : wt);
        h = clamp1(rd ? rh : wh);
        total = s + t + h + g;
        base = 8'($urandom);
        exp_rd = din_pat(base, s + t - 1);
        first_en = -1; en_cnt = 0; act_cnt = 0; done_idx = -1; done_cnt = 0;
        bad_ctl = 0; bad_data = 0; bad_ready = 0; bad_line = 0; got_rd = '0;

        @(negedge clk);
        check(req_ready === 1'b1, "R2", "ready before accept", int'(req_ready), 1);
        req_valid = 1'b1; req_read = rd; req_rs = rs; req_sel = sel; req_wdata = wd;
        cfg_wr_setup = 5'(ws); cfg_wr_strobe = 6'(wt); cfg_wr_hold = 4'(wh);
        cfg_rd_setup = 5'(rsu); cfg_rd_strobe = 6'(rt); cfg_rd_hold = 4'(rh);
        cfg_gap = 4'(g);
        @(posedge clk);
        for (int i = 0; i <= total; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b0;
                req_wdata = ~wd;
                req_rs = ~rs;
            end
            if (mess) scramble_cfg(); // R10: timing inputs change mid-access
            lcd_din = din_pat(base, i);
            if (req_ready !== 1'b0) bad_ready = 1;
            if (lcd_en0 || lcd_en1) begin
                if (first_en < 0) first_en = i;
                en_cnt++;
                if (lcd_en0 !== !sel || lcd_en1 !== sel) bad_line = 1;
            end
            if (lcd_rw || lcd_doe) act_cnt++;
            if (i < s + t + h) begin
                if (lcd_rs !== rs || lcd_rw !== rd) bad_ctl = 1;
                if (lcd_doe !== !rd) bad_data = 1;
                if (!rd && lcd_dout !== {8'h00, wd}) bad_data = 1;
            end else begin
                if (lcd_rs !== 1'b0 || lcd_rw !== 1'b0) bad_ctl = 1;
                if (lcd_doe !== 1'b0 || lcd_dout !== 16'h0) bad_data = 1;
            end
            if (done) begin
                done_cnt++;
                if (done_idx < 0) done_idx = i;
                got_rd = rdata;
            end
        end
        check(first_en == s, "R3", "first strobe cycle", first_en, s);
        check(en_cnt == t && !bad_line, "R4", "strobe cycles on chosen line", en_cnt, t);
        check(act_cnt - s - t == h, "R5", "hold cycles", act_cnt - s - t, h);
        check(done_idx == total && done_cnt == 1, "R6", "done cycle index (R11 counts)",
              done_idx, total);
        check(!bad_ctl, "R7", "rs/rw during access", int'(bad_ctl), 0);
        check(!bad_data, "R8", "data drive and output enable", int'(bad_data), 0);
        check(!bad_ready, "R2", "ready low during access", int'(bad_ready), 0);
        if (rd)
            check(got_rd == exp_rd, "R9", "read byte at done", int'(got_rd), int'(exp_rd));
        @(negedge clk);
        check(req_ready === 1'b1, "R2", "ready after done", int'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1 && done === 1'b0, "R1", "ready/done after reset",
              int'({req_ready, done}), 2);
        check(!lcd_en0 && !lcd_en1 && !lcd_doe && !lcd_rs && !lcd_rw, "R1",
              "bus quiet after reset", int'({lcd_en0, lcd_en1, lcd_doe, lcd_rs, lcd_rw}), 0);

        // Directed corners
        run_access(0, 1, 0, 8'h5A, 0, 3, 2, 9, 9, 9, 0, 0);   // R3 zero setup, R6 zero gap
        run_access(1, 0, 1, 8'h00, 7, 7, 7, 2, 0, 0, 3, 0);   // R4/R5 zero counts act as one
        run_access(0, 0, 1, 8'hC3, 31, 63, 15, 0, 1, 1, 15, 0); // maximum write counts
        run_access(1, 1, 0, 8'h11, 1, 1, 1, 31, 63, 15, 15, 1); // maximum read counts, R10
        run_access(0, 1, 1, 8'hFF, 4, 0, 0, 20, 20, 2, 1, 1);   // R11 read set ignored on write

        // Constrained random accesses
        for (int n = 0; n < 40; n++) begin
            run_access(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                       int'($urandom_range(0, 31)), int'($urandom_range(0, 63)),
                       int'($urandom_range(0, 15)), int'($urandom_range(0, 31)),
                       int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
                       int'($urandom_range(0, 15)), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule